// File: doc/BRIEF.md
# Crystal Oscillator Control Unit

This block manages an external crystal oscillator through a small register file on a simple 32-bit read/write bus. Software turns the oscillator on or off with keyed 12-bit codes and parks it in a low-power dormant state with a keyed 32-bit code. A programmable startup timer holds back the "stable" indication after every start. An active-high wake input brings the oscillator out of dormancy without software. Any write whose value is not one of the accepted keys is rejected or forced to a safe value, and it raises a sticky error flag.

The analog oscillator is represented by a single clock-enable output, `osc_clk_en`. The system clock stands in for the crystal clock, so every timer in the block advances once per clock cycle while the oscillator is running. A small 8-bit down counter runs at the crystal rate and gives software a short, self-stopping delay.

The bus has a single access strobe `bus_en` and a write qualifier `bus_we`. A write takes effect at the clock edge where both are high. Reads are combinational from `bus_addr`. Register offsets are 0x00 control, 0x04 status, 0x08 dormant, 0x0C startup and 0x1C count.

Top module: `xtal_osc_ctrl`

## Requirements
- R1: After reset the registers read as follows. Control reads 0x00D1EAA0. Status reads 0. Dormant reads 0x77616B65. Startup reads 0. Count reads 0. `osc_clk_en` is 0.
- R2: Writing control bits 23:12 = 0xFAB sets the enabled state. Writing 0xD1E clears it. Control bits 23:12 read back as the code for the current state, and status bit 12 reads as the enabled state.
- R3: Control bits 11:0 always read 0xAA0, whatever is written to them. A control write whose bits 23:12 hold neither valid code leaves the enabled state unchanged.
- R4: Status bit 24 (bad write) is set by any of three writes: a control write with an invalid enable code, a control write with bits 11:0 other than 0xAA0, or a dormant write other than 0x636F6D61 or 0x77616B65. Once set, the flag stays set.
- R5: A status write with bit 24 = 1 clears the bad-write flag. A status write with bit 24 = 0 leaves it set.
- R6: Status bit 31 (stable) is 1 only while the oscillator is running and the startup timer is at zero. On enable from the disabled state, or on wake, the timer loads D×256, or D×1024 when startup bit 20 is set, where D is startup bits 13:0. It counts down once per running cycle, so stable rises exactly that many clock edges after the starting edge.
- R7: Writing 0x636F6D61 to the dormant register enters dormant mode, which clears `osc_clk_en` and stable. Writing 0x77616B65 wakes the oscillator and restarts the startup timer. Any other value also selects wake. The dormant register reads back the code of the current state.
- R8: While dormant, a high `wake_i` at a clock edge returns the dormant register to the wake state and restarts the startup timer. If the same edge also carries a dormant-code write, the wake takes priority.
- R9: Writing the count register (offset 0x1C) loads its low 8 bits. The counter decrements once per cycle while `osc_clk_en` is 1, stops at zero, and holds its value while `osc_clk_en` is 0.
- R10: The startup register keeps bits 13:0 and bit 20 and reads all other bits as 0. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wake_i | input | 1 | Active-high wake request from dormant mode |
| osc_clk_en | output | 1 | Oscillator run enable (enabled and not dormant) |

## Verification
The hardest condition to reach from the ports is the exact edge where stable rises after a long startup count, especially with the x4 multiplier and after a wake. The bench programs small delay values so the timer loads 256, 512 or 1024. It then counts clock edges from the starting write or the `wake_i` pulse, and checks stable on the edge before the expected rise and on the rise itself. The counter-freeze case is reached by entering dormancy and then disabling in the middle of a count.

// File: rtl/xtal_osc_ctrl.sv
module xtal_osc_ctrl #(
  parameter int ADDR_W = 6,
  parameter int DLY_W  = 14,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              wake_i,
  output logic              osc_clk_en
);
  localparam logic [11:0] KEY_ON   = 12'hFAB;
  localparam logic [11:0] KEY_OFF  = 12'hD1E;
  localparam logic [11:0] RANGE    = 12'hAA0;
  localparam logic [31:0] KEY_DORM = 32'h636F6D61;
  localparam logic [31:0] KEY_WAKE = 32'h77616B65;
  localparam int          TMR_W    = DLY_W + 10;
  localparam int          X4_BIT   = 20;

  logic             enabled, dormant, bad, x4_q;
  logic [DLY_W-1:0] dly_q;
  logic [TMR_W-1:0] tmr_q, load_val;
  logic [CNT_W-1:0] cnt_q;

  wire wr      = bus_en & bus_we;
  wire wr_ctrl = wr && bus_addr == ADDR_W'(8'h00);
  wire wr_stat = wr && bus_addr == ADDR_W'(8'h04);
  wire wr_dorm = wr && bus_addr == ADDR_W'(8'h08);
  wire wr_strt = wr && bus_addr == ADDR_W'(8'h0C);
  wire wr_cnt  = wr && bus_addr == ADDR_W'(8'h1C);

  wire [11:0] en_key  = bus_wdata[23:12];
  wire        key_ok  = en_key == KEY_ON || en_key == KEY_OFF;
  wire        dorm_ok = bus_wdata == KEY_DORM || bus_wdata == KEY_WAKE;
  wire        bad_set = (wr_ctrl && (!key_ok || bus_wdata[11:0] != RANGE)) ||
                        (wr_dorm && !dorm_ok);

  wire pin_wake = dormant & wake_i;
  wire sw_wake  = wr_dorm & dormant & (bus_wdata != KEY_DORM);
  wire turn_on  = wr_ctrl & (en_key == KEY_ON) & ~enabled;
  wire start    = turn_on | pin_wake | sw_wake;

  assign osc_clk_en = enabled & ~dormant;
  wire   stable     = osc_clk_en && tmr_q == '0;

  assign load_val = x4_q ? {dly_q, 10'b0} : {2'b0, dly_q, 8'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= 1'b0;
      dormant <= 1'b0;
      bad     <= 1'b0;
      x4_q    <= 1'b0;
      dly_q   <= '0;
      tmr_q   <= '0;
      cnt_q   <= '0;
    end else begin
      if (wr_ctrl && key_ok) enabled <= (en_key == KEY_ON);

      if (pin_wake)     dormant <= 1'b0;
      else if (wr_dorm) dormant <= (bus_wdata == KEY_DORM);

      if (bad_set)                     bad <= 1'b1;
      else if (wr_stat && bus_wdata[24]) bad <= 1'b0;

      if (wr_strt) begin
        dly_q <= bus_wdata[DLY_W-1:0];
        x4_q  <= bus_wdata[X4_BIT];
      end

      if (start)                          tmr_q <= load_val;
      else if (osc_clk_en && tmr_q != '0) tmr_q <= tmr_q - 1'b1;

      if (wr_cnt)                         cnt_q <= bus_wdata[CNT_W-1:0];
      else if (osc_clk_en && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(8'h00): bus_rdata = {8'b0, enabled ? KEY_ON : KEY_OFF, RANGE};
      ADDR_W'(8'h04): bus_rdata = {stable, 6'b0, bad, 11'b0, enabled, 12'b0};
      ADDR_W'(8'h08): bus_rdata = dormant ? KEY_DORM : KEY_WAKE;
      ADDR_W'(8'h0C): bus_rdata = 32'(dly_q) | (32'(x4_q) << X4_BIT);
      ADDR_W'(8'h1C): bus_rdata = 32'(cnt_q);
      default:        bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/xtal_osc_ctrl_chk.sv
module xtal_osc_ctrl_chk #(
  parameter int ADDR_W = 6,
  parameter int DLY_W  = 14,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              wake_i,
  input logic              osc_clk_en,
  input logic              enabled,
  input logic              dormant,
  input logic              bad,
  input logic              stable,
  input logic [DLY_W-1:0]  dly_q,
  input logic [CNT_W-1:0]  cnt_q
);
  wire wr      = bus_en & bus_we;
  wire wr_ctrl = wr && bus_addr == ADDR_W'(8'h00);
  wire wr_stat = wr && bus_addr == ADDR_W'(8'h04);
  wire wr_dorm = wr && bus_addr == ADDR_W'(8'h08);
  wire wr_cnt  = wr && bus_addr == ADDR_W'(8'h1C);

  AST_ENABLE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[23:12] == 12'hFAB) |=> enabled); // R2
  AST_BAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && !(wr_stat && bus_wdata[24])) |=> bad); // R4
  AST_BAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[24]) |=> !bad); // R5
  AST_START_HOLDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[23:12] == 12'hFAB && !enabled && dly_q != '0) |=> !stable); // R6
  AST_DORMANT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dorm && bus_wdata == 32'h636F6D61 && !wake_i) |=> (!osc_clk_en && !stable)); // R7
  AST_WAKE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (dormant && wake_i) |=> !dormant); // R8
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_clk_en && !wr_cnt) |=> $stable(cnt_q)); // R9
  AST_COUNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !wr_cnt) |=> cnt_q == '0); // R9
endmodule

bind xtal_osc_ctrl xtal_osc_ctrl_chk #(.ADDR_W(ADDR_W), .DLY_W(DLY_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .wake_i(wake_i), .osc_clk_en(osc_clk_en), .enabled(enabled),
  .dormant(dormant), .bad(bad), .stable(stable), .dly_q(dly_q), .cnt_q(cnt_q)
);

// File: tb/xtal_osc_ctrl_tb_top.sv
module xtal_osc_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] A_CTRL = 32'h00, A_STAT = 32'h04, A_DORM = 32'h08,
                          A_STRT = 32'h0C, A_CNT = 32'h1C;
  localparam logic [31:0] C_ON  = 32'h00FABAA0, C_OFF = 32'h00D1EAA0;
  localparam logic [31:0] K_DORM = 32'h636F6D61, K_WAKE = 32'h77616B65;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0, wake_i = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic osc_clk_en;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xtal_osc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_i(wake_i), .osc_clk_en(osc_clk_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a[5:0]; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [31:0] a, input logic [31:0] exp);
    bus_addr = a[5:0];
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", A_CTRL, C_OFF);
    rd_chk("R1 status", A_STAT, 32'h0);
    rd_chk("R1 dormant", A_DORM, K_WAKE);
    rd_chk("R1 startup", A_STRT, 32'h0);
    rd_chk("R1 count", A_CNT, 32'h0);
    chk("R1 clk_en", {31'b0, osc_clk_en}, 32'h0);
  endtask

  task automatic t_ctrl;
    wr(A_CTRL, C_ON);
    rd_chk("R2 ctrl on", A_CTRL, C_ON);
    rd_chk("R2 status on", A_STAT, 32'h80001000);
    chk("R2 clk_en on", {31'b0, osc_clk_en}, 32'h1);
    wr(A_CTRL, 32'h00123AA0);
    rd_chk("R3 bad key keeps state", A_STAT, 32'h81001000);
    wr(A_STAT, 32'h01000000);
    rd_chk("R5 clear", A_STAT, 32'h80001000);
    wr(A_CTRL, 32'h00FAB555);
    rd_chk("R3 range fixed", A_CTRL, C_ON);
    rd_chk("R4 range bad", A_STAT, 32'h81001000);
    wr(A_STAT, 32'h0);
    rd_chk("R5 zero keeps", A_STAT, 32'h81001000);
    wr(A_STAT, 32'h01000000);
    wr(A_CTRL, C_OFF);
    rd_chk("R2 status off", A_STAT, 32'h0);
    chk("R2 clk_en off", {31'b0, osc_clk_en}, 32'h0);
  endtask

  task automatic t_dorm_bad;
    wr(A_DORM, K_DORM);
    wr(A_DORM, 32'h12345678);
    rd_chk("R7 invalid selects wake", A_DORM, K_WAKE);
    rd_chk("R4 dormant bad", A_STAT, 32'h01000000);
    idle(3);
    rd_chk("R4 sticky", A_STAT, 32'h01000000);
    wr(A_STAT, 32'h01000000);
  endtask

  task automatic t_timer;
    wr(A_STRT, 32'h1);
    wr(A_CTRL, C_ON);
    idle(255);
    rd_chk("R6 not yet 256", A_STAT, 32'h00001000);
    idle(1);
    rd_chk("R6 stable 256", A_STAT, 32'h80001000);
    wr(A_CTRL, C_OFF);
    wr(A_STRT, 32'h00100001);
    rd_chk("R10 startup x4", A_STRT, 32'h00100001);
    wr(A_CTRL, C_ON);
    idle(1023);
    rd_chk("R6 not yet 1024", A_STAT, 32'h00001000);
    idle(1);
    rd_chk("R6 stable 1024", A_STAT, 32'h80001000);
    wr(A_CTRL, C_OFF);
    wr(A_STRT, 32'hFFFFFFFF);
    rd_chk("R10 startup mask", A_STRT, 32'h00103FFF);
  endtask

  task automatic t_dormant;
    wr(A_STRT, 32'h0);
    wr(A_CTRL, C_ON);
    wr(A_DORM, K_DORM);
    rd_chk("R7 dormant read", A_DORM, K_DORM);
    rd_chk("R7 status dormant", A_STAT, 32'h00001000);
    chk("R7 clk_en dormant", {31'b0, osc_clk_en}, 32'h0);
    wr(A_STRT, 32'h2);
    wr(A_DORM, K_WAKE);
    chk("R7 clk_en wake", {31'b0, osc_clk_en}, 32'h1);
    idle(511);
    rd_chk("R7 wake not yet", A_STAT, 32'h00001000);
    idle(1);
    rd_chk("R7 wake stable", A_STAT, 32'h80001000);
  endtask

  task automatic t_wake_pin;
    wr(A_DORM, K_DORM);
    idle(2);
    chk("R8 asleep", {31'b0, osc_clk_en}, 32'h0);
    wake_i = 1'b1;
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = A_DORM[5:0]; bus_wdata = K_DORM;
    @(negedge clk);
    wake_i = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
    rd_chk("R8 wake wins", A_DORM, K_WAKE);
    chk("R8 clk_en", {31'b0, osc_clk_en}, 32'h1);
    idle(511);
    rd_chk("R8 not yet", A_STAT, 32'h00001000);
    idle(1);
    rd_chk("R8 stable", A_STAT, 32'h80001000);
  endtask

  task automatic t_count;
    wr(A_CNT, 32'h0000010A);
    rd_chk("R9 load low byte", A_CNT, 32'd10);
    idle(4);
    rd_chk("R9 counting", A_CNT, 32'd6);
    idle(10);
    rd_chk("R9 stops at zero", A_CNT, 32'd0);
    wr(A_CNT, 32'd20);
    wr(A_DORM, K_DORM);
    rd_chk("R9 last step", A_CNT, 32'd19);
    idle(5);
    rd_chk("R9 frozen dormant", A_CNT, 32'd19);
    wr(A_DORM, K_WAKE);
    rd_chk("R9 wake edge", A_CNT, 32'd19);
    idle(3);
    rd_chk("R9 resumes", A_CNT, 32'd16);
    wr(A_CTRL, C_OFF);
    rd_chk("R9 disable edge", A_CNT, 32'd15);
    idle(5);
    rd_chk("R9 frozen disabled", A_CNT, 32'd15);
  endtask

  task automatic t_map;
    rd_chk("R10 unmapped 10", 32'h10, 32'h0);
    rd_chk("R10 unmapped 14", 32'h14, 32'h0);
    rd_chk("R10 unmapped 18", 32'h18, 32'h0);
    rd_chk("R10 unmapped 20", 32'h20, 32'h0);
  endtask

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_ctrl();
    t_dorm_bad();
    t_timer();
    t_dormant();
    t_wake_pin();
    t_count();
    t_map();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule